// File: doc/BRIEF.md
# Bitwise Arbitrating Serial Transmitter

This block sends a message one byte at a time onto a shared wired bus. On that bus a driven 0 overrides a 1, so 0 is the dominant level and 1 is the recessive level. A separate timing generator supplies a strobe for each bit slot, a marker for the start-of-frame slot, a flag that shows the bus is idle, and the bit it sampled back from the bus. After a transmit request the block takes the message bytes over a valid/ready handshake. It waits until the bus is idle and a start-of-frame is marked, then shifts each byte out most significant bit first, one bit per slot strobe.

At every bit slot of the message, headers and payload alike, the block compares the bit it drove with the bit it read back. If it drove a 1 and read a 0, another node holds a lower and therefore higher-priority bit sequence, and this node has lost arbitration. A loss on any bit except the last bit of a byte stops the drive at once. A loss on the last bit of a byte is followed by up to two extra recessive bits, and each of them is arbitrated in turn. The second extra bit is sent only if the first one survives. A sticky lost flag then blocks the block until the host clears it. A frame that finishes without a loss ends with a one-cycle done pulse.

Top module: `wired_arb_tx`

## Requirements
- R1: Whenever no message bit is being sent (idle, waiting, after a loss, during the appended bits), `tx_bit_o` is 1.
- R2: After `start_i`, the first message bit is driven only after a cycle in which `sof_i` and `bus_idle_i` are both 1 and a byte is held. A `sof_i` while `bus_idle_i` is 0 is ignored, and so are slot strobes before the start.
- R3: Bytes are sent most significant bit first, one bit per `slot_i` strobe. `tx_bit_o` moves to the next bit in the cycle after the strobe.
- R4: If `rx_bit_i` is 0 at a strobe where the block drove 1, and this is not bit index 7 of a byte (index 0 is the MSB), then `arb_lost_o` rises in the next cycle and no further bit of the message is driven.
- R5: A loss at bit index 7 of a byte sets `arb_lost_o` and is followed by one appended recessive slot. If that slot reads back 1, a second appended recessive slot follows, and then the block stops. `clear_lost_i` has no effect until the stop.
- R6: If the first appended slot reads back 0, the second appended slot is not sent, and the block stops at once.
- R7: Arbitration is checked on every bit of every byte of the message, not only the first byte.
- R8: When this node drives 0 and another node drives 1, this node keeps sending. The numerically lowest bit sequence wins.
- R9: `arb_lost_o` stays 1 until `clear_lost_i` arrives after the stop. While it is 1, `byte_ready_o` is 0 and `start_i` is ignored.
- R10: After the strobe for the last bit of the last byte with no loss, `done_o` is 1 for exactly one cycle and the block returns to idle.
- R11: `byte_ready_o` is 1 only while a request is active, the byte register is empty, and the byte marked last has not yet been taken. It is 0 in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Transmit request pulse, taken in idle only |
| clear_lost_i | input | 1 | Clears the sticky lost flag after the stop |
| byte_valid_i | input | 1 | Byte offered |
| byte_data_i | input | BYTE_W | Byte to send, MSB first |
| byte_last_i | input | 1 | Offered byte is the last one of the message |
| byte_ready_o | output | 1 | Byte register can take a byte |
| bus_idle_i | input | 1 | Bus reported idle |
| sof_i | input | 1 | Start-of-frame slot marker |
| slot_i | input | 1 | Bit-slot strobe; `rx_bit_i` is valid with it |
| rx_bit_i | input | 1 | Bit sampled back from the bus |
| tx_bit_o | output | 1 | Bit to drive; 1 is recessive |
| arb_lost_o | output | 1 | Sticky arbitration-lost flag |
| done_o | output | 1 | One-cycle pulse when a frame ends without a loss |

## Verification
The bound assertions check the following on every cycle:
- The drive is recessive whenever the lost flag is set.
- A read-back 0 under a driven 1 during the message always sets the flag.
- The flag is sticky.
- The handshake is closed while the flag is set.
- The done pulse lasts one cycle.
- A frame starts only from an idle bus with a start-of-frame marker.

Other behaviour only the bench scenarios can show, against a second modelled node that shares the wired bus:
- The MSB-first bit order.
- The choice between stopping at once and appending extra bits, and whether the second appended bit is sent.
- A node driving 0 winning against a node driving 1.
- A start-of-frame during a busy bus being ignored.

// File: rtl/wat_pkg.sv
// Shared types for the wired-bus arbitrating transmitter.
package wat_pkg;
    // Control states of the transmitter.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // no request
        ST_WAIT = 3'd1,   // request taken, waiting for idle bus and SOF
        ST_SEND = 3'd2,   // shifting message bits
        ST_EXT1 = 3'd3,   // first appended recessive slot
        ST_EXT2 = 3'd4,   // second appended recessive slot
        ST_LOST = 3'd5    // stopped after a loss, waiting for clear
    } tx_state_e;
endpackage

// File: rtl/wat_shifter.sv
// Byte register and bit counter.
// Holds one byte, offers its MSB, and shifts left once per step. It shows
// when the current bit is the last bit of the byte. It also remembers
// whether the byte marked last has been taken.
// Assumes load and shift never coincide (load needs empty, shift needs full).
module wat_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              last_i,
    input  logic              shift_i,
    output logic              full_o,
    output logic              msb_o,
    output logic              at_end_o,
    output logic              last_o
);
    localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              full_q;
    logic              last_q;

    // Load, shift and count the bits of the current byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            full_q <= 1'b0;
            last_q <= 1'b0;
        end else if (load_i) begin
            sh_q   <= data_i;
            cnt_q  <= '0;
            full_q <= 1'b1;
            last_q <= last_i;
        end else if (shift_i) begin
            if (cnt_q == CNT_END) begin
                full_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                sh_q  <= sh_q << 1;
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign full_o   = full_q;
    assign msb_o    = sh_q[BYTE_W-1];
    assign at_end_o = (cnt_q == CNT_END);
    assign last_o   = last_q;
endmodule

// File: rtl/wat_fsm.sv
// Arbitration control.
// Sequences the request, wait, send, extension and stop states. It compares
// the driven bit with the read-back bit at each slot strobe. It keeps the
// sticky lost flag and makes the done pulse.
// Assumes rx_bit_i is valid whenever slot_i is 1.
module wat_fsm
    import wat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic clear_lost_i,
    input  logic bus_idle_i,
    input  logic sof_i,
    input  logic slot_i,
    input  logic rx_bit_i,
    input  logic full_i,
    input  logic msb_i,
    input  logic at_end_i,
    input  logic last_i,
    output logic shift_o,
    output logic clr_o,
    output logic accept_ok_o,
    output logic tx_bit_o,
    output logic lost_o,
    output logic done_o,
    output logic sending_o
);
    tx_state_e st_q, st_d;
    logic      lose_now;
    logic      step;
    logic      lost_q;
    logic      done_q;

    // A driven 1 read back as 0 during the message is a loss.
    assign lose_now = (st_q == ST_SEND) && slot_i && full_i && msb_i && !rx_bit_i;
    // Advance one bit when the slot passes without a loss.
    assign step = (st_q == ST_SEND) && slot_i && full_i && !lose_now;

    // Pick the next control state.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: if (start_i) st_d = ST_WAIT;
            ST_WAIT: if (bus_idle_i && sof_i && full_i) st_d = ST_SEND;
            ST_SEND: begin
                if (lose_now)                       st_d = at_end_i ? ST_EXT1 : ST_LOST;
                else if (step && at_end_i && last_i) st_d = ST_IDLE;
            end
            ST_EXT1: if (slot_i) st_d = rx_bit_i ? ST_EXT2 : ST_LOST;
            ST_EXT2: if (slot_i) st_d = ST_LOST;
            ST_LOST: if (clear_lost_i) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Sticky lost flag: set on a loss, cleared only once stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   lost_q <= 1'b0;
        else if (lose_now)                            lost_q <= 1'b1;
        else if (st_q == ST_LOST && clear_lost_i)     lost_q <= 1'b0;
    end

    // One-cycle done pulse after the final bit slot.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= step && at_end_i && last_i;
    end

    assign shift_o     = step;
    assign clr_o       = (st_q == ST_IDLE);
    assign accept_ok_o = ((st_q == ST_WAIT) || (st_q == ST_SEND)) && !full_i && !last_i;
    assign tx_bit_o    = ((st_q == ST_SEND) && full_i) ? msb_i : 1'b1;
    assign lost_o      = lost_q;
    assign done_o      = done_q;
    assign sending_o   = (st_q == ST_SEND);
endmodule

// File: rtl/wired_arb_tx.sv
// Top of the wired-bus arbitrating transmitter.
// Joins the byte register and the arbitration control. The byte handshake
// completes when valid and ready are both 1 at a clock edge.
// Assumes slot, SOF and idle indications come from an external bit-timing unit.
module wired_arb_tx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              clear_lost_i,
    input  logic              byte_valid_i,
    input  logic [BYTE_W-1:0] byte_data_i,
    input  logic              byte_last_i,
    output logic              byte_ready_o,
    input  logic              bus_idle_i,
    input  logic              sof_i,
    input  logic              slot_i,
    input  logic              rx_bit_i,
    output logic              tx_bit_o,
    output logic              arb_lost_o,
    output logic              done_o
);
    logic full, msb, at_end, last_taken;
    logic shift, clr, accept_ok;
    logic frame_active;

    wat_shifter #(.BYTE_W(BYTE_W)) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr),
        .load_i   (byte_valid_i && accept_ok),
        .data_i   (byte_data_i),
        .last_i   (byte_last_i),
        .shift_i  (shift),
        .full_o   (full),
        .msb_o    (msb),
        .at_end_o (at_end),
        .last_o   (last_taken)
    );

    wat_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .clear_lost_i (clear_lost_i),
        .bus_idle_i   (bus_idle_i),
        .sof_i        (sof_i),
        .slot_i       (slot_i),
        .rx_bit_i     (rx_bit_i),
        .full_i       (full),
        .msb_i        (msb),
        .at_end_i     (at_end),
        .last_i       (last_taken),
        .shift_o      (shift),
        .clr_o        (clr),
        .accept_ok_o  (accept_ok),
        .tx_bit_o     (tx_bit_o),
        .lost_o       (arb_lost_o),
        .done_o       (done_o),
        .sending_o    (frame_active)
    );

    assign byte_ready_o = accept_ok;
endmodule

// File: rtl/wat_checks.sv
// Property checker for the wired-bus transmitter, attached to the top by bind.
module wat_checks (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic clear_lost_i,
    input logic bus_idle_i,
    input logic sof_i,
    input logic slot_i,
    input logic rx_bit_i,
    input logic byte_ready_o,
    input logic tx_bit_o,
    input logic arb_lost_o,
    input logic done_o,
    input logic frame_active
);
    // Recessive drive once the flag is set (R1, R4).
    assert_recessive_when_lost_R1: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost_o |-> tx_bit_o);

    // Frame entry needs idle bus and SOF marker.
    assert_start_on_idle_sof_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_active) |-> $past(bus_idle_i && sof_i));

    // Read-back 0 under a driven 1 is a loss, on any message bit.
    assert_loss_detected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_active && slot_i && tx_bit_o && !rx_bit_i && !byte_ready_o |=> arb_lost_o);

    // Flag holds until a clear.
    assert_lost_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost_o && !clear_lost_i |=> arb_lost_o);

    // No byte taken while lost.
    assert_no_accept_lost_R9: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost_o |-> !byte_ready_o);

    // Done lasts one cycle and never with a loss.
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_not_lost_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !arb_lost_o);
endmodule

bind wired_arb_tx wat_checks u_wat_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .clear_lost_i (clear_lost_i),
    .bus_idle_i   (bus_idle_i),
    .sof_i        (sof_i),
    .slot_i       (slot_i),
    .rx_bit_i     (rx_bit_i),
    .byte_ready_o (byte_ready_o),
    .tx_bit_o     (tx_bit_o),
    .arb_lost_o   (arb_lost_o),
    .done_o       (done_o),
    .frame_active (frame_active)
);

// File: tb/wired_arb_tx_bench.sv
`timescale 1ns/100ps
module wired_arb_tx_bench;
    localparam int SLOT_GAP = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, clear_lost_i = 1'b0;
    logic       byte_valid_i = 1'b0, byte_last_i = 1'b0;
    logic [7:0] byte_data_i = 8'h00;
    logic       bus_idle_i = 1'b1, sof_i = 1'b0, slot_i = 1'b0, rx_bit_i = 1'b1;
    logic       byte_ready_o, tx_bit_o, arb_lost_o, done_o;

    wired_arb_tx u_wired_arb_tx (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .clear_lost_i(clear_lost_i),
        .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i), .byte_last_i(byte_last_i),
        .byte_ready_o(byte_ready_o), .bus_idle_i(bus_idle_i), .sof_i(sof_i),
        .slot_i(slot_i), .rx_bit_i(rx_bit_i), .tx_bit_o(tx_bit_o),
        .arb_lost_o(arb_lost_o), .done_o(done_o)
    );

    always #2.5 clk = ~clk;

    int checks = 0, fails = 0, cycles = 0;
    logic [7:0] mb [4];
    logic [7:0] cb [4];
    int  mn, cn;
    bit  abort;
    int  ms;
    string oreq;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Bit of this node's message at slot index pos, MSB first.
    function automatic logic my_bit(input int pos);
        return mb[pos / 8][7 - (pos % 8)];
    endfunction

    // Bit the competing node offers at slot k (recessive after its frame).
    function automatic logic comp_bit(input int k);
        if (k >= cn * 8) return 1'b1;
        return cb[k / 8][7 - (k % 8)];
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic feed();
        for (int i = 0; i < mn; i++) begin
            if (abort) break;
            @(negedge clk);
            byte_valid_i = 1'b1;
            byte_data_i  = mb[i];
            byte_last_i  = (i == mn - 1);
            while (!byte_ready_o && !abort) @(negedge clk);
            if (!abort) @(negedge clk);
            byte_valid_i = 1'b0;
        end
        byte_valid_i = 1'b0;
    endtask

    task automatic drive_slots(input bit busy_pre);
        int  k = 0, pos = 0;
        bit  calive = 1'b1, comp_lost = 1'b0;
        logic e, c, b;
        ms = 0;
        repeat (4) @(negedge clk);
        if (busy_pre) begin
            bus_idle_i = 1'b0; sof_i = 1'b1;
            @(negedge clk); sof_i = 1'b0;
            slot_i = 1'b1; rx_bit_i = 1'b0;
            @(negedge clk); slot_i = 1'b0; rx_bit_i = 1'b1;
            chk("R2 busy sof ignored", tx_bit_o, 1);
            chk("R2 not started", arb_lost_o, 0);
            bus_idle_i = 1'b1;
        end
        sof_i = 1'b1;
        @(negedge clk); sof_i = 1'b0;
        while (ms < 3) begin
            if (ms != 0) begin
                @(negedge clk); clear_lost_i = 1'b1;
                @(negedge clk); clear_lost_i = 1'b0;
                chk("R5 clear held off during extension", arb_lost_o, 1);
            end
            repeat (SLOT_GAP) @(negedge clk);
            e = (ms == 0) ? my_bit(pos) : 1'b1;
            c = calive ? comp_bit(k) : 1'b1;
            b = e & c;
            chk(ms == 0 ? "R3 bit order" : "R1 appended recessive", tx_bit_o, e);
            rx_bit_i = tx_bit_o & c;
            slot_i = 1'b1;
            @(negedge clk);
            slot_i = 1'b0; rx_bit_i = 1'b1;
            if (c && !b) begin calive = 1'b0; comp_lost = 1'b1; end
            case (ms)
                0: if (e && !b) begin
                       if (pos % 8 == 7) begin ms = 1; oreq = "R5"; end
                       else begin ms = 3; oreq = (pos >= 8) ? "R7" : "R4"; end
                   end else begin
                       pos++;
                       if (pos == mn * 8) begin ms = 4; oreq = comp_lost ? "R8" : "R10"; end
                   end
                1: if (!b) begin ms = 3; oreq = "R6"; end else ms = 2;
                default: ms = 3;
            endcase
            k++;
        end
        chk({oreq, " done pulse"}, done_o, ms == 4);
        chk({oreq, " lost flag"}, arb_lost_o, ms == 3);
        if (ms == 3) abort = 1'b1;
        @(negedge clk);
        chk("R10 done one cycle", done_o, 0);
        chk("R1 recessive after frame", tx_bit_o, 1);
    endtask

    task automatic run_frame(input bit busy_pre);
        abort = 1'b0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk("R11 ready in wait", byte_ready_o, 1);
        fork
            feed();
            drive_slots(busy_pre);
        join
        if (ms == 3) begin
            byte_valid_i = 1'b1; byte_data_i = 8'h5A; byte_last_i = 1'b1;
            @(negedge clk);
            chk("R9 byte ignored while lost", byte_ready_o, 0);
            start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;
            chk("R9 start ignored while lost", arb_lost_o, 1);
            chk("R9 still not ready", byte_ready_o, 0);
            byte_valid_i = 1'b0; byte_last_i = 1'b0;
            clear_lost_i = 1'b1;
            @(negedge clk); clear_lost_i = 1'b0;
            chk({oreq, " stopped and clearable"}, arb_lost_o, 0);
            chk("R11 not ready in idle", byte_ready_o, 0);
        end else begin
            chk("R11 not ready in idle", byte_ready_o, 0);
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 reset drive", tx_bit_o, 1);
        chk("R11 reset ready", byte_ready_o, 0);
        chk("R9 reset flag", arb_lost_o, 0);
        chk("R10 reset done", done_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Lone sender, with a SOF on a busy bus first.
        mn = 2; mb[0] = 8'hA5; mb[1] = 8'h3C; cn = 0;
        run_frame(1'b1);
        // Priority 011 against 000: loss on the second bit.
        mn = 1; mb[0] = 8'h60; cn = 1; cb[0] = 8'h00;
        run_frame(1'b0);
        // This node holds the lower sequence and wins.
        mn = 2; mb[0] = 8'h00; mb[1] = 8'h11; cn = 2; cb[0] = 8'h60; cb[1] = 8'hFF;
        run_frame(1'b0);
        // Loss on the last bit of a byte, both appended bits survive.
        mn = 2; mb[0] = 8'h01; mb[1] = 8'hFF; cn = 2; cb[0] = 8'h00; cb[1] = 8'hFF;
        run_frame(1'b0);
        // Loss on the last bit of a byte, first appended bit loses.
        mn = 2; mb[0] = 8'h01; mb[1] = 8'hFF; cn = 2; cb[0] = 8'h00; cb[1] = 8'h7F;
        run_frame(1'b0);
        // Loss deep inside the third byte.
        mn = 3; mb[0] = 8'h12; mb[1] = 8'h34; mb[2] = 8'h80;
        cn = 3; cb[0] = 8'h12; cb[1] = 8'h34; cb[2] = 8'h00;
        run_frame(1'b0);

        for (int f = 0; f < 24; f++) begin
            int mode, p, j;
            mn = 1 + int'($urandom % 4);
            for (int i = 0; i < 4; i++) begin mb[i] = 8'($urandom); cb[i] = mb[i]; end
            mode = int'($urandom % 4);
            cn = mn;
            case (mode)
                0: cn = 0;
                1: begin p = int'($urandom % (mn * 8)); cb[p / 8][7 - p % 8] = ~cb[p / 8][7 - p % 8]; end
                2: begin cn = 1 + int'($urandom % 4); for (int i = 0; i < 4; i++) cb[i] = 8'($urandom); end
                default: begin
                    j = int'($urandom % mn);
                    mb[j][0] = 1'b1;
                    for (int i = 0; i < 4; i++) cb[i] = mb[i];
                    cb[j][0] = 1'b0;
                    cb[(j + 1) % 4] = 8'($urandom);
                    cn = 4;
                end
            endcase
            run_frame(f % 5 == 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule